// File: doc/BRIEF.md
# I2C Power-Manager Register Target

This block is an I2C target that holds the byte registers of a power-management controller. It watches the synchronized SCL and SDA lines for START, repeated START and STOP conditions. It acknowledges its own 7-bit address, 0x34, and pulls SDA low through an open-drain output enable.

Within a write transfer, the first byte after the address sets an internal register pointer. Each further byte is stored at that pointer, and the pointer then steps forward. A read transfer returns the register at the pointer and also steps it forward. The pointer is kept from one transfer to the next, so a host can write only the pointer, issue a repeated START or a new transfer, and read from that register.

A parameter picks one of two sparse tables of reset values. Every other register resets to zero.

Top module: `pmu_reg_target`

## Requirements
- R1: The target acknowledges address byte 0x68 (7-bit address 0x34, write) and 0x69 (read). Any other address gets no acknowledge, and the target leaves SDA released until the next START.
- R2: In a write transfer, the first data byte after the address loads the register pointer, is acknowledged and is not stored.
- R3: Each write byte after the pointer byte is acknowledged and stored at the pointer, and the pointer then increments.
- R4: Each read byte, sent MSB first, is the register at the pointer, and the pointer then increments. A master NACK ends the burst, and the target releases SDA until the next START.
- R5: A read with the pointer at 0xFF returns 0xFF and leaves the pointer at 0xFF. The register file covers 0x00 to 0xFE.
- R6: A write byte with the pointer at 0xFF is acknowledged but not stored, and the 8-bit pointer wraps to 0x00.
- R7: START, repeated START and STOP each mark the next written byte as a pointer byte. None of them changes the pointer.
- R8: Reset clears the pointer and the byte state and sets every register to 0x00, then loads the variant table. Variant 0 holds 0x01 at 0x03, 0x16 at 0x23 and 0xD8 at 0x40.
- R9: Variant 1 holds 0xC2 at 0x00, 0x06 at 0x03, 0x60 at 0x30 and 0xD8 at 0x40. In the status byte at 0x00, bit 7 means AC input present, bit 6 AC input usable, bit 5 USB input present, bit 4 USB input in use, bit 2 battery charging and bit 1 system fed from AC or USB.
- R10: SDA is driven only by sda_oe_o (1 pulls the line low). After the two-flop synchronizer, sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The assertions check the following on every cycle:
- sda_oe_o only changes in a cycle where the synchronized SCL was low.
- Every bus condition returns the byte state to "pointer next" and, for STOP, leaves the pointer unchanged.
- A read at 0xFF never moves the pointer.
- The register file is never written at 0xFF.

Only the bench's bus scenarios can show the following:
- Stored values reach the right registers through auto-increment and wrap.
- The pointer survives STOP and repeated START.
- Foreign addresses are ignored.
- Each variant's reset table holds the right values.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WRITE, ST_READ, ST_SKIP
  } bus_state_e;

  function automatic logic [7:0] reset_byte(input int variant, input int idx);
    logic [7:0] v;
    v = 8'h00;
    if (variant == 0) begin
      case (idx)
        8'h03: v = 8'h01;
        8'h23: v = 8'h16;
        8'h40: v = 8'hD8;
        default: v = 8'h00;
      endcase
    end else begin
      case (idx)
        8'h00: v = 8'hC2;  // ac present | ac usable | system on external
        8'h03: v = 8'h06;
        8'h30: v = 8'h60;
        8'h40: v = 8'hD8;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/pmu_sync.sv
module pmu_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pmu_bus_events.sv
module pmu_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/pmu_regfile.sv
module pmu_regfile #(
  parameter int VARIANT = 0,
  parameter int DEPTH   = 255,
  parameter int AW      = 8,
  parameter int DW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(pmu_pkg::reset_byte(VARIANT, i));
    end else if (we_i && (int'(waddr_i) < DEPTH)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : '1;
endmodule

// File: rtl/pmu_i2c_fsm.sv
module pmu_i2c_fsm #(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         DEPTH    = 255,
  parameter int         AW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_s_i,
  input  logic [7:0]    rdata_i,
  output logic          sda_oe_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic [AW-1:0] ptr_o,
  output logic          ptr_set_o,
  output logic          fetch_o
);
  import pmu_pkg::*;

  bus_state_e    state_q;
  logic [3:0]    bit_cnt_q;
  logic          ack_ph_q, rnw_q, ptr_set_q, oe_q;
  logic [7:0]    shreg_q, tx_q;
  logic [AW-1:0] ptr_q;
  logic          byte_done, ptr_top, evt;

  assign evt       = start_i | stop_i;
  assign byte_done = scl_fall_i & ~evt & ~ack_ph_q & (bit_cnt_q == 4'd8);
  assign ptr_top   = int'(ptr_q) >= DEPTH;
  assign fetch_o   = scl_fall_i & ~evt & ack_ph_q &
                     ((state_q == ST_ADDR & rnw_q) | state_q == ST_READ);
  assign we_o      = byte_done & (state_q == ST_WRITE) & ptr_set_q & ~ptr_top;
  assign wdata_o   = shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      rnw_q     <= 1'b0;
      ptr_set_q <= 1'b0;
      oe_q      <= 1'b0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
    end else if (evt) begin
      state_q   <= start_i ? ST_ADDR : ST_IDLE;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      ptr_set_q <= 1'b0;
      oe_q      <= 1'b0;
    end else if (scl_rise_i) begin
      if (!ack_ph_q && bit_cnt_q < 4'd8) begin
        shreg_q   <= {shreg_q[6:0], sda_s_i};
        bit_cnt_q <= bit_cnt_q + 4'd1;
      end else if (ack_ph_q && state_q == ST_READ && sda_s_i) begin
        state_q <= ST_SKIP;  // master NACK
      end
    end else if (fetch_o) begin
      state_q   <= ST_READ;
      ack_ph_q  <= 1'b0;
      bit_cnt_q <= '0;
      tx_q      <= rdata_i;
      oe_q      <= ~rdata_i[7];
      if (!ptr_top) ptr_q <= ptr_q + 1'b1;
    end else if (scl_fall_i) begin
      unique case (state_q)
        ST_ADDR, ST_WRITE: begin
          if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (shreg_q[7:1] == DEV_ADDR) begin
                oe_q     <= 1'b1;
                ack_ph_q <= 1'b1;
                rnw_q    <= shreg_q[0];
              end else begin
                state_q <= ST_SKIP;
              end
            end else begin
              oe_q     <= 1'b1;
              ack_ph_q <= 1'b1;
              if (!ptr_set_q) begin
                ptr_q     <= shreg_q[AW-1:0];
                ptr_set_q <= 1'b1;
              end else begin
                ptr_q <= ptr_q + 1'b1;
              end
            end
          end else if (ack_ph_q) begin
            oe_q      <= 1'b0;
            ack_ph_q  <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= ST_WRITE;
          end
        end
        ST_READ: begin
          if (bit_cnt_q == 4'd8) begin
            oe_q     <= 1'b0;
            ack_ph_q <= 1'b1;
          end else if (bit_cnt_q != 4'd0) begin
            tx_q <= {tx_q[6:0], 1'b0};
            oe_q <= ~tx_q[6];
          end
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign ptr_set_o = ptr_set_q;
endmodule

// File: rtl/pmu_reg_target.sv
module pmu_reg_target #(
  parameter int         VARIANT  = 0,
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         DEPTH    = 255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int AW = $clog2(DEPTH + 1);

  logic          scl_s, sda_s;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic          we, ptr_set, fetch;
  logic [7:0]    wdata, rdata;
  logic [AW-1:0] ptr;

  pmu_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  pmu_bus_events u_events (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  pmu_i2c_fsm #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH), .AW(AW)) u_fsm (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .sda_s_i(sda_s),
    .rdata_i(rdata), .sda_oe_o, .we_o(we), .wdata_o(wdata),
    .ptr_o(ptr), .ptr_set_o(ptr_set), .fetch_o(fetch)
  );

  pmu_regfile #(.VARIANT(VARIANT), .DEPTH(DEPTH), .AW(AW), .DW(8)) u_regs (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(ptr), .wdata_i(wdata),
    .raddr_i(ptr), .rdata_o(rdata)
  );
endmodule

// File: rtl/pmu_reg_target_chk.sv
module pmu_reg_target_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          sda_oe_o,
  input logic          start_det,
  input logic          stop_det,
  input logic          ptr_set,
  input logic [AW-1:0] ptr,
  input logic          fetch,
  input logic          we
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));  // R10
  AST_EVT_CLR_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det || stop_det) |=> !ptr_set);  // R7
  AST_STOP_KEEP_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> $stable(ptr));  // R7
  AST_TOP_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch && ptr == '1) |=> ptr == '1);  // R5
  AST_TOP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> ptr != '1);  // R6
endmodule

bind pmu_reg_target pmu_reg_target_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .scl_s, .sda_oe_o, .start_det, .stop_det,
  .ptr_set, .ptr, .fetch, .we
);

// File: tb/pmu_reg_target_tb.sv
module pmu_reg_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [7:0] AW_B = 8'h68;
  localparam logic [7:0] AR_B = 8'h69;
  // {pointer, write data, expected read}
  localparam logic [23:0] VEC [8] = '{
    24'h10_A5_A5, 24'h23_3C_3C, 24'h7F_00_00, 24'h80_FF_FF,
    24'hFE_5A_5A, 24'hFF_77_FF, 24'h40_12_12, 24'h01_C3_C3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_low = 1'b0, sel = 1'b0;
  logic oe0, oe1, sda0, sda1, scl0, scl1, sda_bus;
  int   checks = 0, errors = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl0    = sel ? 1'b1 : m_scl;
  assign scl1    = sel ? m_scl : 1'b1;
  assign sda0    = ~(m_low | oe0);
  assign sda1    = ~(m_low | oe1);
  assign sda_bus = sel ? sda1 : sda0;

  pmu_reg_target #(.VARIANT(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl0), .sda_i(sda0), .sda_oe_o(oe0));
  pmu_reg_target #(.VARIANT(1)) dut_v1_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl1), .sda_i(sda1), .sda_oe_o(oe1));

  task automatic wait_q(int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic put_bit(bit b);
    wait_q(); m_low = ~b; wait_q(); m_scl = 1'b1; wait_q(); m_scl = 1'b0;
  endtask

  task automatic get_bit(output bit b);
    wait_q(); m_low = 1'b0; wait_q(); m_scl = 1'b1;
    wait_q(Q/2); b = sda_bus; wait_q(Q - Q/2); m_scl = 1'b0;
  endtask

  task automatic bus_start();
    m_low = 1'b0; m_scl = 1'b1; wait_q(); m_low = 1'b1; wait_q(); m_scl = 1'b0;
  endtask

  task automatic bus_rstart();
    wait_q(); m_low = 1'b0; wait_q(); m_scl = 1'b1; wait_q(); m_low = 1'b1;
    wait_q(); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_q(); m_low = 1'b1; wait_q(); m_scl = 1'b1; wait_q(); m_low = 1'b0; wait_q();
  endtask

  task automatic wr_byte(logic [7:0] b, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic rd_byte(bit ack, output logic [7:0] d);
    bit v;
    for (int i = 7; i >= 0; i--) begin get_bit(v); d[i] = v; end
    put_bit(~ack);
  endtask

  task automatic write_reg(logic [7:0] p, logic [7:0] d);
    bit a;
    bus_start(); wr_byte(AW_B, a); wr_byte(p, a); wr_byte(d, a); bus_stop();
  endtask

  task automatic read_at(logic [7:0] p, output logic [7:0] d);
    bit a;
    bus_start(); wr_byte(AW_B, a); wr_byte(p, a);
    bus_rstart(); wr_byte(AR_B, a); rd_byte(1'b0, d); bus_stop();
  endtask

  task automatic read_here(output logic [7:0] d);
    bit a;
    bus_start(); wr_byte(AR_B, a); rd_byte(1'b0, d); bus_stop();
  endtask

  initial begin
    logic [7:0] d;
    bit a;
    wait_q(4);
    rst_n = 1'b1;
    wait_q(4);
    check("R10 reset oe", {7'd0, oe0}, 8'h00);
    // R8 variant 0 reset table
    read_at(8'h03, d); check("R8 id 0x03", d, 8'h01);
    read_at(8'h23, d); check("R8 0x23", d, 8'h16);
    read_at(8'h40, d); check("R8 0x40", d, 8'hD8);
    read_at(8'h30, d); check("R8 0x30 zero", d, 8'h00);
    // R1 own address acked, foreign ignored
    bus_start(); wr_byte(AW_B, a); check("R1 own ack", {7'd0, a}, 8'h01); bus_stop();
    bus_start(); wr_byte(8'h6A, a); check("R1 foreign nack", {7'd0, a}, 8'h00);
    wr_byte(8'h00, a); check("R1 foreign data nack", {7'd0, a}, 8'h00); bus_stop();
    // vector table: R2 R3 R6 R5
    foreach (VEC[i]) begin
      write_reg(VEC[i][23:16], VEC[i][15:8]);
      read_at(VEC[i][23:16], d);
      check("R3 vector readback", d, VEC[i][7:0]);
    end
    // R3 burst write with ack per byte, R4 burst read
    bus_start(); wr_byte(AW_B, a); wr_byte(8'h50, a);
    check("R2 pointer ack", {7'd0, a}, 8'h01);
    wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a);
    check("R3 data ack", {7'd0, a}, 8'h01); bus_stop();
    bus_start(); wr_byte(AW_B, a); wr_byte(8'h50, a); bus_rstart(); wr_byte(AR_B, a);
    rd_byte(1'b1, d); check("R4 burst 0", d, 8'h11);
    rd_byte(1'b1, d); check("R4 burst 1", d, 8'h22);
    rd_byte(1'b0, d); check("R4 burst 2", d, 8'h33);
    wait_q(); check("R4 release after nack", {7'd0, oe0}, 8'h00); bus_stop();
    read_at(8'h4F, d); check("R2 pointer byte not stored", d, 8'h00);
    // R7 pointer kept across STOP
    bus_start(); wr_byte(AW_B, a); wr_byte(8'h51, a); bus_stop();
    read_here(d); check("R7 pointer kept", d, 8'h22);
    read_here(d); check("R4 increment across transfers", d, 8'h33);
    // R7 repeated START makes next byte a pointer
    bus_start(); wr_byte(AW_B, a); wr_byte(8'h60, a); wr_byte(8'hAA, a);
    bus_rstart(); wr_byte(AW_B, a); wr_byte(8'h61, a); wr_byte(8'hBB, a); bus_stop();
    read_at(8'h60, d); check("R7 first byte", d, 8'hAA);
    read_at(8'h61, d); check("R7 rstart pointer", d, 8'hBB);
    read_at(8'h62, d); check("R7 no spill", d, 8'h00);
    // R5 reading through the top
    bus_start(); wr_byte(AW_B, a); wr_byte(8'hFE, a); bus_rstart(); wr_byte(AR_B, a);
    rd_byte(1'b1, d); check("R5 0xFE", d, 8'h5A);
    rd_byte(1'b1, d); check("R5 0xFF", d, 8'hFF);
    rd_byte(1'b0, d); check("R5 no advance", d, 8'hFF); bus_stop();
    read_here(d); check("R5 pointer held", d, 8'hFF);
    // R6 write wraps past 0xFF
    bus_start(); wr_byte(AW_B, a); wr_byte(8'hFE, a); wr_byte(8'h01, a);
    wr_byte(8'h02, a); check("R6 ack at top", {7'd0, a}, 8'h01);
    wr_byte(8'h03, a); bus_stop();
    read_at(8'hFE, d); check("R6 0xFE", d, 8'h01);
    read_at(8'h00, d); check("R6 wrap to 0x00", d, 8'h03);
    read_at(8'hFF, d); check("R6 top discarded", d, 8'hFF);
    // R9 variant 1 table
    sel = 1'b1; wait_q();
    read_at(8'h00, d); check("R9 status", d, 8'hC2);
    read_at(8'h03, d); check("R9 id", d, 8'h06);
    read_at(8'h30, d); check("R9 0x30", d, 8'h60);
    read_at(8'h40, d); check("R9 0x40", d, 8'hD8);
    read_at(8'h23, d); check("R9 0x23 zero", d, 8'h00);
    // R8 reset restores cleared registers
    sel = 1'b0; wait_q();
    rst_n = 1'b0; wait_q(4); rst_n = 1'b1; wait_q(4);
    read_at(8'h60, d); check("R8 cleared on reset", d, 8'h00);
    read_at(8'h40, d); check("R8 table reloaded", d, 8'hD8);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule